// File: doc/BRIEF.md
# UART receive frame buffer

This block sits between the receive shift register of a serial port and the processor side. The shift register hands over each completed frame as a single-cycle strobe carrying up to nine data bits, a framing-error bit and a parity-error bit. The block queues frames in a two-slot circular queue. Each slot keeps its own error bits, its ninth data bit and its overrun mark, so the status the processor reads always belongs to the frame it is about to take.

When both slots are occupied, a newly finished frame is parked in a hold register. This register stands for the shift register's own contents and gives a third level of storage. The parked frame moves into the queue one clock after a slot frees up. An overrun is only declared when the front end signals a new start bit while all three levels are full and no read happens in that cycle. In that case the parked frame is dropped, because the shift register is about to be overwritten, and the next frame to be stored carries the overrun mark.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset, rx_ready is 0 and rx_data, rx_ferr, rx_perr and rx_ovr are all 0.
- R2: Frames come out in arrival order. rx_ready is 1 exactly while at least one unread frame is stored, and it rises on the clock edge that captures a frame into an empty queue. Each rd_pop on a non-empty queue removes exactly one frame.
- R3: rx_ferr, rx_perr and rx_data (including its top, ninth bit) show the values that were captured with the frame at the head of the queue. After a pop they show the next frame's values.
- R4: A frame that completes while two frames are stored is not lost. It is delivered after the two older frames and enters the queue on the clock edge after the one that freed a slot.
- R5: A start_det pulse while two frames are stored, a frame is parked and rd_pop is low discards the parked frame. The next frame written then carries rx_ovr=1, and this mark leaves the outputs when that frame is popped.
- R6: A start_det pulse while no frame is parked sets no overrun mark.
- R7: rd_pop on an empty queue has no effect. A frame stored afterwards is read out normally.
- R8: While rx_en is 0, the queue, the parked frame and any pending overrun mark are cleared, and frame_valid is ignored.
- R9: While rx_ready is 0, rx_data, rx_ferr, rx_perr and rx_ovr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes all stored state |
| frame_valid | input | 1 | One-cycle strobe: a frame has completed |
| frame_data | input | DW | Data bits of the completed frame (bit DW-1 is the ninth bit) |
| frame_ferr | input | 1 | Framing error of the completed frame |
| frame_perr | input | 1 | Parity error of the completed frame |
| start_det | input | 1 | One-cycle strobe: the next start bit was detected |
| rd_pop | input | 1 | Processor read: remove the head frame |
| rx_ready | output | 1 | At least one unread frame is stored |
| rx_data | output | DW | Data of the head frame |
| rx_ferr | output | 1 | Framing error of the head frame |
| rx_perr | output | 1 | Parity error of the head frame |
| rx_ovr | output | 1 | Overrun mark of the head frame |

## Verification
The hardest case to reach is the overrun. It needs both slots filled and a third frame parked, then a start-bit strobe in a cycle with no read. After that, a further frame must arrive so that the mark has something to travel with. The stimulus builds this up by sending three frames with no read between them, pulsing start_det alone, and sending a fourth frame. The scoreboard removes the dropped frame from its expected list and expects the mark only on the fourth frame. It then sends one more frame to confirm that the mark does not stick.

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          frame_valid,
  input  logic [DW-1:0] frame_data,
  input  logic          frame_ferr,
  input  logic          frame_perr,
  input  logic          start_det,
  input  logic          rd_pop,
  output logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_ferr,
  output logic          rx_perr,
  output logic          rx_ovr
);
  localparam int EW = DW + 3;

  logic [EW-1:0] slot [2];
  logic          rd_ptr, wr_ptr;
  logic [1:0]    cnt;
  logic [EW-1:0] held;
  logic          held_v, ovr_pend;

  wire           full      = (cnt == 2'd2);
  wire           do_pop    = rd_pop && (cnt != 2'd0);
  wire           wr        = !full && (held_v || frame_valid);
  wire [EW-1:0]  in_ent    = {ovr_pend, frame_perr, frame_ferr, frame_data};
  wire [EW-1:0]  wr_ent    = held_v ? held : in_ent;
  wire           take_hold = frame_valid && (full || held_v);
  wire           ovr_hit   = start_det && held_v && full && !rd_pop;
  wire [EW-1:0]  head      = slot[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= 1'b0;
      wr_ptr   <= 1'b0;
      cnt      <= 2'd0;
      held     <= '0;
      held_v   <= 1'b0;
      ovr_pend <= 1'b0;
      slot[0]  <= '0;
      slot[1]  <= '0;
    end else if (!rx_en) begin
      rd_ptr   <= 1'b0;
      wr_ptr   <= 1'b0;
      cnt      <= 2'd0;
      held_v   <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      if (wr) begin
        slot[wr_ptr] <= wr_ent;
        wr_ptr       <= ~wr_ptr;
      end
      if (do_pop) rd_ptr <= ~rd_ptr;
      cnt <= cnt + 2'(wr) - 2'(do_pop);

      if (take_hold) begin
        held   <= in_ent;
        held_v <= 1'b1;
      end else if (ovr_hit || (wr && held_v)) begin
        held_v <= 1'b0;
      end

      if (ovr_hit) ovr_pend <= 1'b1;
      else if (take_hold || (wr && !held_v)) ovr_pend <= 1'b0;
    end
  end

  assign rx_ready = (cnt != 2'd0);
  assign rx_data  = rx_ready ? head[DW-1:0] : '0;
  assign rx_ferr  = rx_ready & head[DW];
  assign rx_perr  = rx_ready & head[DW+1];
  assign rx_ovr   = rx_ready & head[DW+2];

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);

  p_first_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && frame_valid && !held_v && cnt == 2'd0 |=> rx_ready);

  p_hold_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && held_v && !full |=> rx_ready && (!held_v || $past(frame_valid)));

  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && ovr_hit && !frame_valid |=> ovr_pend && !held_v && full);

  p_no_false_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !ovr_pend && !held_v |=> !ovr_pend);

  p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !rx_ready && !frame_valid && !held_v |=> !rx_ready);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_ready && !held_v && !ovr_pend);

  p_quiet_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> rx_data == '0 && !rx_ferr && !rx_perr && !rx_ovr);
endmodule

// File: tb/test_rx_frame_buffer.sv
module test_rx_frame_buffer;
  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0;
  logic          frame_valid = 1'b0;
  logic [DW-1:0] frame_data = '0;
  logic          frame_ferr = 1'b0;
  logic          frame_perr = 1'b0;
  logic          start_det = 1'b0;
  logic          rd_pop = 1'b0;
  logic          rx_ready;
  logic [DW-1:0] rx_data;
  logic          rx_ferr, rx_perr, rx_ovr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit exp_ovr = 1'b0;
  logic [DW+2:0] q [$];

  always #4 clk = ~clk;

  rx_frame_buffer #(.DW(DW)) i_rx_frame_buffer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frame_valid(frame_valid),
    .frame_data(frame_data), .frame_ferr(frame_ferr), .frame_perr(frame_perr),
    .start_det(start_det), .rd_pop(rd_pop), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input logic fe, input logic pe);
    @(negedge clk);
    frame_valid = 1'b1; frame_data = d; frame_ferr = fe; frame_perr = pe;
    @(negedge clk);
    frame_valid = 1'b0;
    if (rx_en) begin
      q.push_back({exp_ovr, pe, fe, d});
      exp_ovr = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0;
  endtask

  task automatic pop_check(input string req);
    logic [DW+2:0] e;
    @(negedge clk);
    e = q.pop_front();
    check(req, {31'd0, rx_ready}, 32'd1);
    check(req, {20'd0, rx_ovr, rx_perr, rx_ferr, rx_data}, {20'd0, e});
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    check(req, {31'd0, rx_ready}, 32'd0);
    check(req, {20'd0, rx_ovr, rx_perr, rx_ferr, rx_data}, 32'd0);
  endtask

  initial begin
    #40000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_empty("R1 reset");
    rst_n = 1'b1; rx_en = 1'b1;
    expect_empty("R9 idle");

    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
    expect_empty("R7 pop empty");
    send(9'h055, 1'b0, 1'b0);
    check("R2 ready rise", {31'd0, rx_ready}, 32'd1);
    pop_check("R7 after empty pop");
    expect_empty("R2 one removed");

    send(9'h1A5, 1'b1, 1'b0);
    send(9'h03C, 1'b0, 1'b1);
    pop_check("R3 ninth bit and ferr");
    pop_check("R3 perr next entry");
    expect_empty("R2 drained");

    send(9'h101, 1'b0, 1'b0);
    send(9'h002, 1'b1, 1'b1);
    send(9'h1F3, 1'b1, 1'b0);
    pop_check("R4 first");
    pop_check("R4 second");
    pop_check("R4 held frame");
    expect_empty("R4 exactly three");

    send(9'h011, 1'b0, 1'b0);
    send(9'h022, 1'b0, 1'b0);
    pulse_start();
    send(9'h033, 1'b0, 1'b1);
    pop_check("R6 no overrun a");
    pop_check("R6 no overrun b");
    pop_check("R6 no overrun c");
    expect_empty("R6 drained");

    send(9'h0A0, 1'b0, 1'b0);
    send(9'h0A1, 1'b0, 1'b0);
    send(9'h0A2, 1'b0, 1'b0);
    pulse_start();
    void'(q.pop_back());
    exp_ovr = 1'b1;
    send(9'h1A3, 1'b1, 1'b0);
    pop_check("R5 older a");
    pop_check("R5 older b");
    pop_check("R5 marked frame");
    expect_empty("R5 dropped frame gone");
    send(9'h0A4, 1'b0, 1'b0);
    pop_check("R5 mark cleared");

    send(9'h0B0, 1'b0, 1'b0);
    send(9'h0B1, 1'b0, 1'b0);
    send(9'h0B2, 1'b0, 1'b0);
    pulse_start();
    @(negedge clk); rx_en = 1'b0;
    q.delete(); exp_ovr = 1'b0;
    expect_empty("R8 flushed");
    send(9'h0EE, 1'b1, 1'b1);
    expect_empty("R8 ignored while off");
    @(negedge clk); rx_en = 1'b1;
    expect_empty("R8 held flushed");
    send(9'h0C0, 1'b0, 1'b0);
    pop_check("R8 no stale overrun");
    expect_empty("R8 end");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule